// File: doc/BRIEF.md
# DDR4 Column Command Turnaround Checker

This block watches the command stream of one DDR4 channel and judges every column command (read, write, and their auto-precharge forms) against the commands issued before it. Each timing rule is bound to a scope: the same bank, the same bank group, the same rank, or a different rank. A rule only counts an earlier command that falls inside its scope. The block keeps a saturating "cycles since last issue" timer for each scope and each command family. In the same cycle as the command, it reports whether the command is legal and which rule is broken first.

The read/write and write/read turnaround distances are not given directly. They are derived at elaboration from base latencies, the burst length over the data rate, the preamble lengths, the write-to-read recovery times and the rank-switch gap. Derived values that come out negative are clamped to zero. Activates, power-down exits and self-refresh exits are recorded only as history for the column rules. They are never judged themselves.

All delays are counted in clock cycles. A command code of zero is an idle slot. The block records every non-idle command as history, whether or not it was flagged.

Top module: `ddr4_col_checker`

## Requirements
- R1: After reset no history exists, so any column command is legal. Idle (code 0), activate (code 1), active power-down exit (code 6) and self-refresh exit (code 7) always give ruleId 0 and colLegal 1. colLegal is 1 exactly when ruleId is 0.
- R2: A column command to a bank less than RCD−AL cycles after an activate to that same bank gives rule 1. An activate to any other bank has no effect.
- R3: A column command less than XSDLL cycles after a self-refresh exit to its rank gives rule 2. One less than XP cycles after an active power-down exit to its rank gives rule 3.
- R4: Read family (codes 2 read, 4 read-auto-precharge) after read family, or write family (codes 3 write, 5 write-auto-precharge) after write family, within one bank group and closer than CCD_L gives rule 10. Within the rank but in a different bank group and closer than CCD_S, it gives rule 11.
- R5: Same-family commands to different ranks closer than BURST+RTRS give rule 12, where BURST = BURST_LEN/DATA_RATE.
- R6: A write family command less than RL+BURST+1−WL+WPRE after a read family command in the same rank gives rule 8. Less than RL+BURST+RTRS−WL+WPRE after one in another rank, it gives rule 9.
- R7: A read family command after a write family command gives a rule when it comes too early. In the same bank group, less than WL+BURST+WTR_L−AL gives rule 5. In a different bank group of the same rank, less than WL+BURST+WTR_S−AL gives rule 6. In another rank, less than WL+BURST+RTRS−RL+RPRE gives rule 7.
- R8: A read-auto-precharge less than max(WL+BURST+WTR_L−AL, WL+BURST+WR−RTP−AL) cycles after a write family command to the same bank gives rule 4.
- R9: History from the command's own rank never triggers a cross-rank rule (7, 9, 12).
- R10: When several rules are violated at once, the lowest-numbered one is reported.
- R11: A flagged command is still recorded as history and constrains later commands.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdCode | input | 3 | 0 idle, 1 activate, 2 read, 3 write, 4 read-AP, 5 write-AP, 6 power-down exit, 7 self-refresh exit |
| cmdRank | input | RANK_W | Target rank |
| cmdGroup | input | GROUP_W | Target bank group |
| cmdBank | input | BANK_W | Target bank within the group |
| colLegal | output | 1 | High when the present command breaks no rule |
| ruleId | output | 4 | Lowest-numbered broken rule, 0 if none |

## Verification
The hardest case to reach from the ports is a command that breaks several scoped rules at once. An example is a read-auto-precharge that is too close both to a same-bank write and to a same-group write. Reaching it needs histories in three scopes and two ranks, placed at exact cycle distances. Directed sequences build each such arrangement with counted idle gaps. A long pseudo-random sweep then mixes codes and addresses so that windows overlap. Every cycle is compared with a behavioural model that keeps issue times as integers.

// File: rtl/col_check_pkg.sv
package col_check_pkg;

  typedef enum logic [2:0] {
    CMD_IDLE = 3'd0,
    CMD_ACT  = 3'd1,
    CMD_RD   = 3'd2,
    CMD_WR   = 3'd3,
    CMD_RDA  = 3'd4,
    CMD_WRA  = 3'd5,
    CMD_PDX  = 3'd6,
    CMD_SRX  = 3'd7
  } colCmd_e;

  typedef enum logic [3:0] {
    RULE_NONE      = 4'd0,
    RULE_ACT_COL   = 4'd1,
    RULE_SREF_EXIT = 4'd2,
    RULE_PD_EXIT   = 4'd3,
    RULE_WR_RDA    = 4'd4,
    RULE_WRRD_BG   = 4'd5,
    RULE_WRRD_RANK = 4'd6,
    RULE_WRRD_XR   = 4'd7,
    RULE_RDWR_RANK = 4'd8,
    RULE_RDWR_XR   = 4'd9,
    RULE_SAME_BG   = 4'd10,
    RULE_SAME_RANK = 4'd11,
    RULE_SAME_XR   = 4'd12
  } colRule_e;

  typedef struct packed {
    logic recAct;
    logic recRd;
    logic recWr;
    logic recPdx;
    logic recSrx;
  } colStrobe_t;

  function automatic int clampNonNeg(input int v);
    return (v < 0) ? 0 : v;
  endfunction

  function automatic int maxInt(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/age_timer.sv
module age_timer #(
  parameter int AGE_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             restart,
  output logic [AGE_W-1:0] age
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  always_ff @(posedge clk) begin
    if (!rstN)               age <= AGE_MAX;
    else if (restart)        age <= AGE_W'(1);
    else if (age != AGE_MAX) age <= age + 1'b1;
  end

  AST_AGE_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    restart |=> (age == AGE_W'(1))); // R11
  AST_AGE_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (!restart && age != AGE_MAX) |=> (age == AGE_W'($past(age) + 1'b1))); // R11
endmodule

// File: rtl/col_history.sv
module col_history
  import col_check_pkg::*;
#(
  parameter int NR    = 2,
  parameter int NG    = 4,
  parameter int NB    = 4,
  parameter int AGE_W = 6,
  parameter int RW    = 1,
  parameter int GW    = 2,
  parameter int BW    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  colStrobe_t       strobe,
  input  logic [RW-1:0]    rank,
  input  logic [GW-1:0]    grp,
  input  logic [BW-1:0]    bank,
  output logic [AGE_W-1:0] ageAct,
  output logic [AGE_W-1:0] ageWrBank,
  output logic [AGE_W-1:0] ageRdBg,
  output logic [AGE_W-1:0] ageWrBg,
  output logic [AGE_W-1:0] ageRdRank,
  output logic [AGE_W-1:0] ageWrRank,
  output logic [AGE_W-1:0] ageRdXr,
  output logic [AGE_W-1:0] ageWrXr,
  output logic [AGE_W-1:0] agePdx,
  output logic [AGE_W-1:0] ageSrx
);
  localparam logic [AGE_W-1:0] AGE_MAX = '1;

  logic [AGE_W-1:0] actAge    [NR][NG][NB];
  logic [AGE_W-1:0] wrBankAge [NR][NG][NB];
  logic [AGE_W-1:0] rdBgAge   [NR][NG];
  logic [AGE_W-1:0] wrBgAge   [NR][NG];
  logic [AGE_W-1:0] rdRankAge [NR];
  logic [AGE_W-1:0] wrRankAge [NR];
  logic [AGE_W-1:0] pdxAge    [NR];
  logic [AGE_W-1:0] srxAge    [NR];

  for (genvar r = 0; r < NR; r++) begin : g_rank
    logic rankHit;
    assign rankHit = (rank == RW'(r));
    age_timer #(.AGE_W(AGE_W)) i_rdRank (.clk(clk), .rstN(rstN),
      .restart(strobe.recRd && rankHit), .age(rdRankAge[r]));
    age_timer #(.AGE_W(AGE_W)) i_wrRank (.clk(clk), .rstN(rstN),
      .restart(strobe.recWr && rankHit), .age(wrRankAge[r]));
    age_timer #(.AGE_W(AGE_W)) i_pdx (.clk(clk), .rstN(rstN),
      .restart(strobe.recPdx && rankHit), .age(pdxAge[r]));
    age_timer #(.AGE_W(AGE_W)) i_srx (.clk(clk), .rstN(rstN),
      .restart(strobe.recSrx && rankHit), .age(srxAge[r]));
    for (genvar g = 0; g < NG; g++) begin : g_grp
      logic grpHit;
      assign grpHit = rankHit && (grp == GW'(g));
      age_timer #(.AGE_W(AGE_W)) i_rdBg (.clk(clk), .rstN(rstN),
        .restart(strobe.recRd && grpHit), .age(rdBgAge[r][g]));
      age_timer #(.AGE_W(AGE_W)) i_wrBg (.clk(clk), .rstN(rstN),
        .restart(strobe.recWr && grpHit), .age(wrBgAge[r][g]));
      for (genvar b = 0; b < NB; b++) begin : g_bank
        logic bankHit;
        assign bankHit = grpHit && (bank == BW'(b));
        age_timer #(.AGE_W(AGE_W)) i_act (.clk(clk), .rstN(rstN),
          .restart(strobe.recAct && bankHit), .age(actAge[r][g][b]));
        age_timer #(.AGE_W(AGE_W)) i_wrBank (.clk(clk), .rstN(rstN),
          .restart(strobe.recWr && bankHit), .age(wrBankAge[r][g][b]));
      end
    end
  end

  assign ageAct    = actAge[rank][grp][bank];
  assign ageWrBank = wrBankAge[rank][grp][bank];
  assign ageRdBg   = rdBgAge[rank][grp];
  assign ageWrBg   = wrBgAge[rank][grp];
  assign ageRdRank = rdRankAge[rank];
  assign ageWrRank = wrRankAge[rank];
  assign agePdx    = pdxAge[rank];
  assign ageSrx    = srxAge[rank];

  // Youngest history among all ranks other than the addressed one.
  always_comb begin
    ageRdXr = AGE_MAX;
    ageWrXr = AGE_MAX;
    for (int r = 0; r < NR; r++) begin
      if (RW'(r) != rank) begin
        if (rdRankAge[r] < ageRdXr) ageRdXr = rdRankAge[r];
        if (wrRankAge[r] < ageWrXr) ageWrXr = wrRankAge[r];
      end
    end
  end
endmodule

// File: rtl/col_rules.sv
module col_rules
  import col_check_pkg::*;
#(
  parameter int AGE_W      = 6,
  parameter int D_ACT_COL  = 16,
  parameter int D_XSDLL    = 40,
  parameter int D_XP       = 7,
  parameter int D_WR_RDA   = 27,
  parameter int D_WRRD_L   = 25,
  parameter int D_WRRD_S   = 19,
  parameter int D_WRRD_R   = 3,
  parameter int D_RDWR     = 10,
  parameter int D_RDWR_R   = 11,
  parameter int D_CCD_L    = 6,
  parameter int D_CCD_S    = 4,
  parameter int D_CCD_R    = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       cmdCode,
  input  logic [AGE_W-1:0] ageAct,
  input  logic [AGE_W-1:0] ageWrBank,
  input  logic [AGE_W-1:0] ageRdBg,
  input  logic [AGE_W-1:0] ageWrBg,
  input  logic [AGE_W-1:0] ageRdRank,
  input  logic [AGE_W-1:0] ageWrRank,
  input  logic [AGE_W-1:0] ageRdXr,
  input  logic [AGE_W-1:0] ageWrXr,
  input  logic [AGE_W-1:0] agePdx,
  input  logic [AGE_W-1:0] ageSrx,
  output colStrobe_t       strobe,
  output logic [3:0]       ruleId,
  output logic             colLegal
);
  localparam logic [AGE_W-1:0] L_ACT    = AGE_W'(D_ACT_COL);
  localparam logic [AGE_W-1:0] L_XSDLL  = AGE_W'(D_XSDLL);
  localparam logic [AGE_W-1:0] L_XP     = AGE_W'(D_XP);
  localparam logic [AGE_W-1:0] L_WR_RDA = AGE_W'(D_WR_RDA);
  localparam logic [AGE_W-1:0] L_WRRD_L = AGE_W'(D_WRRD_L);
  localparam logic [AGE_W-1:0] L_WRRD_S = AGE_W'(D_WRRD_S);
  localparam logic [AGE_W-1:0] L_WRRD_R = AGE_W'(D_WRRD_R);
  localparam logic [AGE_W-1:0] L_RDWR   = AGE_W'(D_RDWR);
  localparam logic [AGE_W-1:0] L_RDWR_R = AGE_W'(D_RDWR_R);
  localparam logic [AGE_W-1:0] L_CCD_L  = AGE_W'(D_CCD_L);
  localparam logic [AGE_W-1:0] L_CCD_S  = AGE_W'(D_CCD_S);
  localparam logic [AGE_W-1:0] L_CCD_R  = AGE_W'(D_CCD_R);

  colCmd_e  cmd;
  colRule_e rule;
  logic isRd, isWr, isCol;
  logic [AGE_W-1:0] sameBgAge, sameRankAge, sameXrAge;

  assign cmd   = colCmd_e'(cmdCode);
  assign isRd  = (cmd == CMD_RD) || (cmd == CMD_RDA);
  assign isWr  = (cmd == CMD_WR) || (cmd == CMD_WRA);
  assign isCol = isRd || isWr;

  assign strobe.recAct = (cmd == CMD_ACT);
  assign strobe.recRd  = isRd;
  assign strobe.recWr  = isWr;
  assign strobe.recPdx = (cmd == CMD_PDX);
  assign strobe.recSrx = (cmd == CMD_SRX);

  assign sameBgAge   = isRd ? ageRdBg   : ageWrBg;
  assign sameRankAge = isRd ? ageRdRank : ageWrRank;
  assign sameXrAge   = isRd ? ageRdXr   : ageWrXr;

  // Lowest rule number wins: the chain is ordered by rule number.
  always_comb begin
    rule = RULE_NONE;
    if (isCol) begin
      if (ageAct < L_ACT)                            rule = RULE_ACT_COL;
      else if (ageSrx < L_XSDLL)                     rule = RULE_SREF_EXIT;
      else if (agePdx < L_XP)                        rule = RULE_PD_EXIT;
      else if (cmd == CMD_RDA && ageWrBank < L_WR_RDA) rule = RULE_WR_RDA;
      else if (isRd && ageWrBg < L_WRRD_L)           rule = RULE_WRRD_BG;
      else if (isRd && ageWrRank < L_WRRD_S)         rule = RULE_WRRD_RANK;
      else if (isRd && ageWrXr < L_WRRD_R)           rule = RULE_WRRD_XR;
      else if (isWr && ageRdRank < L_RDWR)           rule = RULE_RDWR_RANK;
      else if (isWr && ageRdXr < L_RDWR_R)           rule = RULE_RDWR_XR;
      else if (sameBgAge < L_CCD_L)                  rule = RULE_SAME_BG;
      else if (sameRankAge < L_CCD_S)                rule = RULE_SAME_RANK;
      else if (sameXrAge < L_CCD_R)                  rule = RULE_SAME_XR;
    end
  end

  assign ruleId   = rule;
  assign colLegal = (rule == RULE_NONE);

  AST_PASSIVE_CMDS: assert property (@(posedge clk) disable iff (!rstN)
    !isCol |-> (ruleId == RULE_NONE)); // R1
  AST_ACT_GUARD: assert property (@(posedge clk) disable iff (!rstN)
    (isCol && ageAct < L_ACT) |-> (ruleId == RULE_ACT_COL)); // R2
  AST_RDA_WR: assert property (@(posedge clk) disable iff (!rstN)
    (cmd == CMD_RDA && ageAct >= L_ACT && ageSrx >= L_XSDLL && agePdx >= L_XP
     && ageWrBank < L_WR_RDA) |-> (ruleId == RULE_WR_RDA)); // R8
  AST_XR_SAME_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (ruleId == RULE_SAME_XR) |-> (sameXrAge < L_CCD_R)); // R5
  AST_XR_WRRD_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    (ruleId == RULE_WRRD_XR) |-> (ageWrXr < L_WRRD_R)); // R9
endmodule

// File: rtl/ddr4_col_checker.sv
module ddr4_col_checker
  import col_check_pkg::*;
#(
  parameter int NUM_RANKS       = 2,
  parameter int NUM_GROUPS      = 4,
  parameter int BANKS_PER_GROUP = 4,
  parameter int RANK_W  = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1,
  parameter int GROUP_W = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  parameter int BANK_W  = (BANKS_PER_GROUP > 1) ? $clog2(BANKS_PER_GROUP) : 1,
  parameter int T_RCD   = 16,
  parameter int T_AL    = 0,
  parameter int T_RL    = 16,
  parameter int T_WL    = 12,
  parameter int T_RPRE  = 1,
  parameter int T_WPRE  = 1,
  parameter int T_CCD_S = 4,
  parameter int T_CCD_L = 6,
  parameter int T_RTRS  = 2,
  parameter int T_WTR_S = 3,
  parameter int T_WTR_L = 9,
  parameter int T_RTP   = 9,
  parameter int T_WR    = 20,
  parameter int T_XP    = 7,
  parameter int T_XSDLL = 40,
  parameter int BURST_LEN = 8,
  parameter int DATA_RATE = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [2:0]         cmdCode,
  input  logic [RANK_W-1:0]  cmdRank,
  input  logic [GROUP_W-1:0] cmdGroup,
  input  logic [BANK_W-1:0]  cmdBank,
  output logic               colLegal,
  output logic [3:0]         ruleId
);
  localparam int BURST     = BURST_LEN / DATA_RATE;
  localparam int D_ACT_COL = clampNonNeg(T_RCD - T_AL);
  localparam int D_XSDLL   = clampNonNeg(T_XSDLL);
  localparam int D_XP      = clampNonNeg(T_XP);
  localparam int D_WRRD_L  = clampNonNeg(T_WL + BURST + T_WTR_L - T_AL);
  localparam int D_WRRD_S  = clampNonNeg(T_WL + BURST + T_WTR_S - T_AL);
  localparam int D_WRRD_R  = clampNonNeg(T_WL + BURST + T_RTRS - T_RL + T_RPRE);
  localparam int D_WR_RDA  = maxInt(D_WRRD_L, clampNonNeg(T_WL + BURST + T_WR - T_RTP - T_AL));
  localparam int D_RDWR    = clampNonNeg(T_RL + BURST + 1 - T_WL + T_WPRE);
  localparam int D_RDWR_R  = clampNonNeg(T_RL + BURST + T_RTRS - T_WL + T_WPRE);
  localparam int D_CCD_L   = clampNonNeg(T_CCD_L);
  localparam int D_CCD_S   = clampNonNeg(T_CCD_S);
  localparam int D_CCD_R   = clampNonNeg(BURST + T_RTRS);
  localparam int MAX_D = maxInt(maxInt(maxInt(D_ACT_COL, D_XSDLL), maxInt(D_XP, D_WR_RDA)),
                         maxInt(maxInt(maxInt(D_WRRD_S, D_WRRD_R), maxInt(D_RDWR, D_RDWR_R)),
                                maxInt(maxInt(D_CCD_L, D_CCD_S), D_CCD_R)));
  localparam int AGE_W = maxInt(1, $clog2(MAX_D + 1));

  colStrobe_t strobe;
  logic [AGE_W-1:0] ageAct, ageWrBank, ageRdBg, ageWrBg, ageRdRank, ageWrRank;
  logic [AGE_W-1:0] ageRdXr, ageWrXr, agePdx, ageSrx;

  col_rules #(
    .AGE_W(AGE_W), .D_ACT_COL(D_ACT_COL), .D_XSDLL(D_XSDLL), .D_XP(D_XP),
    .D_WR_RDA(D_WR_RDA), .D_WRRD_L(D_WRRD_L), .D_WRRD_S(D_WRRD_S), .D_WRRD_R(D_WRRD_R),
    .D_RDWR(D_RDWR), .D_RDWR_R(D_RDWR_R), .D_CCD_L(D_CCD_L), .D_CCD_S(D_CCD_S),
    .D_CCD_R(D_CCD_R)
  ) i_rules (
    .clk(clk), .rstN(rstN), .cmdCode(cmdCode),
    .ageAct(ageAct), .ageWrBank(ageWrBank), .ageRdBg(ageRdBg), .ageWrBg(ageWrBg),
    .ageRdRank(ageRdRank), .ageWrRank(ageWrRank), .ageRdXr(ageRdXr), .ageWrXr(ageWrXr),
    .agePdx(agePdx), .ageSrx(ageSrx),
    .strobe(strobe), .ruleId(ruleId), .colLegal(colLegal)
  );

  col_history #(
    .NR(NUM_RANKS), .NG(NUM_GROUPS), .NB(BANKS_PER_GROUP), .AGE_W(AGE_W),
    .RW(RANK_W), .GW(GROUP_W), .BW(BANK_W)
  ) i_history (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .rank(cmdRank), .grp(cmdGroup), .bank(cmdBank),
    .ageAct(ageAct), .ageWrBank(ageWrBank), .ageRdBg(ageRdBg), .ageWrBg(ageWrBg),
    .ageRdRank(ageRdRank), .ageWrRank(ageWrRank), .ageRdXr(ageRdXr), .ageWrXr(ageWrXr),
    .agePdx(agePdx), .ageSrx(ageSrx)
  );
endmodule

// File: tb/test_ddr4_col_checker.sv
`timescale 1ns/1ps
module test_ddr4_col_checker;
  // Expected distances, derived here from the default base parameters.
  localparam int BURST  = 8 / 2;
  localparam int E_ACT  = 16 - 0;
  localparam int E_XSD  = 40;
  localparam int E_XP   = 7;
  localparam int E_WRL  = 12 + BURST + 9 - 0;
  localparam int E_WRS  = 12 + BURST + 3 - 0;
  localparam int E_WRR  = 12 + BURST + 2 - 16 + 1;
  localparam int E_RDAW = (E_WRL > 12 + BURST + 20 - 9 - 0) ? E_WRL : 12 + BURST + 20 - 9 - 0;
  localparam int E_RW   = 16 + BURST + 1 - 12 + 1;
  localparam int E_RWR  = 16 + BURST + 2 - 12 + 1;
  localparam int E_CL   = 6;
  localparam int E_CS   = 4;
  localparam int E_CR   = BURST + 2;

  logic clk = 0;
  logic rstN = 0;
  logic [2:0] cmdCode = 0;
  logic [0:0] cmdRank = 0;
  logic [1:0] cmdGroup = 0;
  logic [1:0] cmdBank = 0;
  logic colLegal;
  logic [3:0] ruleId;

  always #2.5 clk = ~clk;

  ddr4_col_checker i_ddr4_col_checker (
    .clk(clk), .rstN(rstN), .cmdCode(cmdCode), .cmdRank(cmdRank),
    .cmdGroup(cmdGroup), .cmdBank(cmdBank), .colLegal(colLegal), .ruleId(ruleId)
  );

  int tests = 0;
  int fails = 0;
  int tNow = 0;
  int lastRule = 0;
  int lAct[2][4][4], lWrBank[2][4][4];
  int lRdBg[2][4], lWrBg[2][4];
  int lRdRk[2], lWrRk[2], lPdx[2], lSrx[2];

  function automatic string tagOf(input int rule);
    case (rule)
      0: return "R1";
      1: return "R2";
      2, 3: return "R3";
      4: return "R8";
      5, 6, 7: return "R7";
      8, 9: return "R6";
      10, 11: return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic int model(input int c, input int r, input int g, input int b);
    int xr;
    bit rd, wr;
    xr = 1 - r;
    rd = (c == 2 || c == 4);
    wr = (c == 3 || c == 5);
    if (!rd && !wr) return 0;
    if (tNow - lAct[r][g][b] < E_ACT) return 1;
    if (tNow - lSrx[r] < E_XSD) return 2;
    if (tNow - lPdx[r] < E_XP) return 3;
    if (c == 4 && tNow - lWrBank[r][g][b] < E_RDAW) return 4;
    if (rd && tNow - lWrBg[r][g] < E_WRL) return 5;
    if (rd && tNow - lWrRk[r] < E_WRS) return 6;
    if (rd && tNow - lWrRk[xr] < E_WRR) return 7;
    if (wr && tNow - lRdRk[r] < E_RW) return 8;
    if (wr && tNow - lRdRk[xr] < E_RWR) return 9;
    if (tNow - (rd ? lRdBg[r][g] : lWrBg[r][g]) < E_CL) return 10;
    if (tNow - (rd ? lRdRk[r] : lWrRk[r]) < E_CS) return 11;
    if (tNow - (rd ? lRdRk[xr] : lWrRk[xr]) < E_CR) return 12;
    return 0;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at step %0d", tag, act, exp, tNow);
    end
  endtask

  task automatic step(input int c, input int r, input int g, input int b);
    int exp;
    @(negedge clk);
    cmdCode = 3'(c); cmdRank = 1'(r); cmdGroup = 2'(g); cmdBank = 2'(b);
    #1;
    exp = model(c, r, g, b);
    lastRule = int'(ruleId);
    chk((int'(ruleId) == exp) && (colLegal == (exp == 0)), tagOf(exp), int'(ruleId), exp);
    case (c)
      1: lAct[r][g][b] = tNow;
      2, 4: begin lRdBg[r][g] = tNow; lRdRk[r] = tNow; end
      3, 5: begin lWrBg[r][g] = tNow; lWrRk[r] = tNow; lWrBank[r][g][b] = tNow; end
      6: lPdx[r] = tNow;
      7: lSrx[r] = tNow;
      default: ;
    endcase
    tNow++;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  initial begin
    #(5.0 * 100000);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] lfsr;
    for (int r = 0; r < 2; r++) begin
      lRdRk[r] = -1000; lWrRk[r] = -1000; lPdx[r] = -1000; lSrx[r] = -1000;
      for (int g = 0; g < 4; g++) begin
        lRdBg[r][g] = -1000; lWrBg[r][g] = -1000;
        for (int b = 0; b < 4; b++) begin lAct[r][g][b] = -1000; lWrBank[r][g][b] = -1000; end
      end
    end
    repeat (4) @(posedge clk);
    #1;
    chk(colLegal == 1'b1 && ruleId == 4'd0, "R1", int'(ruleId), 0);
    @(negedge clk);
    rstN = 1;
    idle(2);
    step(2, 0, 0, 0);                 // R1: first read, no history
    chk(lastRule == 0, "R1", lastRule, 0);
    idle(20);
    // R2 and R11: activate, early read, then read to untouched bank in same group
    step(1, 0, 1, 1); idle(4);
    step(2, 0, 1, 1);
    chk(lastRule == 1, "R2", lastRule, 1);
    step(2, 0, 1, 2);
    chk(lastRule == 10, "R11", lastRule, 10);
    idle(E_ACT);
    step(2, 0, 1, 1);
    idle(20);
    // R3
    step(7, 1, 0, 0); idle(2); step(3, 1, 0, 0);
    chk(lastRule == 2, "R3", lastRule, 2);
    idle(50);
    step(6, 0, 0, 0); step(2, 0, 2, 2);
    chk(lastRule == 3, "R3", lastRule, 3);
    idle(30);
    // R8 / R10: several rules broken at once, lowest reported
    step(3, 0, 3, 3); idle(20); step(4, 0, 3, 3);
    chk(lastRule == 4, "R10", lastRule, 4);
    idle(5); step(4, 0, 3, 3);
    idle(40);
    // R7
    step(3, 0, 2, 0); idle(10); step(2, 0, 2, 1);
    idle(40);
    step(3, 0, 1, 0); idle(10); step(2, 0, 2, 0);
    chk(lastRule != 7, "R9", lastRule, 6);
    idle(40);
    step(3, 1, 0, 0); step(2, 0, 0, 0);
    idle(40);
    // R6
    step(2, 0, 0, 0); idle(3); step(3, 0, 1, 2);
    idle(40);
    step(2, 1, 0, 0); idle(2); step(3, 0, 0, 0);
    idle(40);
    // R4 / R5
    step(2, 0, 0, 0); step(2, 0, 0, 1);
    idle(40);
    step(2, 0, 0, 0); idle(1); step(2, 0, 1, 0);
    idle(40);
    step(3, 1, 0, 0); idle(2); step(3, 0, 0, 0);
    chk(lastRule == 12, "R5", lastRule, 12);
    idle(40);
    step(3, 0, 0, 0); idle(1); step(5, 0, 0, 1);
    chk(lastRule != 12, "R9", lastRule, 10);
    idle(40);
    // pseudo-random sweep
    lfsr = 16'hACE1;
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[11:10] == 2'b00) step(0, 0, 0, 0);
      else step(int'(lfsr[2:0]), int'(lfsr[3]), int'(lfsr[5:4]), int'(lfsr[7:6]));
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule